// File: doc/BRIEF.md
# Fixed-Priority Burst-Granular Channel Arbiter

This block chooses which of several DMA channels may use a single shared bus master port. Each channel raises a request level. A channel whose peripheral runs on another clock passes its request through a two-flop synchronizer. A channel clocked by the same clock as the arbiter can skip that stage, which removes two cycles from its response time. The choice is made per channel by a parameter mask.

When the bus is free, the arbiter picks the pending channel with the lowest index and holds that grant for a whole transaction. A transaction is one read (source) burst, then a fixed number of idle turnaround cycles, then one write (destination) burst. A higher-priority request that arrives during a transaction has to wait until the write burst ends. The data mover signals each accepted beat and marks the last one. A burst that runs to the maximum beat count ends even if no last-beat mark arrives. The outputs are a registered one-hot grant, a phase flag and a bus-busy flag.

Top module: `dma_chan_arbiter`

## Requirements
- R1: During and immediately after reset, the grant is all zeros and busy and phase are 0.
- R2: When the bus is idle, the arbiter grants the pending channel with the lowest index; bit i of the grant corresponds to channel i.
- R3: The grant has at most one bit set on every cycle.
- R4: Once a channel is granted, the grant stays unchanged until the last beat of its write burst. A request from any other channel, including a higher-priority one, does not change the grant during that time.
- R5: After the read burst ends, busy is 0 for exactly TURN_GAP cycles while the grant is held and phase is 1 (write pending). After that, busy returns to 1 with phase 1 for the write burst. During the read burst, busy is 1 and phase is 0.
- R6: The cycle after the write burst's last beat, the grant is cleared and busy is 0. A pending request is granted one cycle after that.
- R7: A request on a bypassed channel that is high at a clock edge while the bus is idle is granted at that edge. A request on a synchronized channel is granted two edges later.
- R8: Beat and last-beat strobes received while no burst is active have no effect, including during the turnaround gap.
- R9: A burst ends after MAX_BEATS beats even if the last-beat strobe is never raised.
- R10: Requests are sampled as levels only at the arbitration cycle. A request that rises and falls while a transaction is in progress is never granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_CH | Request level per channel |
| beat_i | input | 1 | One beat of the current burst was accepted by the bus |
| last_i | input | 1 | Qualifies beat_i as the final beat of the burst |
| gnt_o | output | NUM_CH | One-hot grant to the owning channel |
| phase_o | output | 1 | 0 = read (source) phase, 1 = write (destination) pending or active |
| busy_o | output | 1 | Bus master port is in a burst |

## Verification
On every cycle, the assertions check that the grant is one-hot or zero, that busy is never set without a grant, that the grant cannot move until the write burst closes, that the turnaround gap keeps the bus idle while holding the grant, that the release happens on the cycle after the write burst's last beat, and the two-cycle delay through each synchronizer. Several behaviours can only be shown by the bench's scenarios. These are: which channel wins for a given mix of requests, the exact length of the turnaround gap, the latency difference between bypassed and synchronized channels, a higher-priority channel waiting through a whole transaction, the forced end of a burst at the beat cap, and strobes or short request pulses that must be ignored.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_GAP  = 2'd2,
    ST_WR   = 2'd3
  } arb_state_e;
endpackage

// File: rtl/dca_req_sync.sv
module dca_req_sync #(
  parameter bit BYPASS = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (BYPASS) begin : g_direct
      assign q_o = d_i;
    end else begin : g_two_flop
      logic stage1, stage2;
      always_ff @(posedge clk) begin
        if (rst) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= d_i;
          stage2 <= stage1;
        end
      end
      assign q_o = stage2;

      // Checker counter: wait two cycles after reset before comparing against history.
      logic [1:0] settle;
      always_ff @(posedge clk) begin
        if (rst) settle <= 2'd0;
        else if (settle != 2'd2) settle <= settle + 2'd1;
      end

      p_sync_delay_r7: assert property (@(posedge clk) disable iff (rst)
        (settle == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/dca_prio_pick.sv
module dca_prio_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] pick_o,
  output logic              any_o
);
  always_comb begin
    pick_o = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick_o    = '0;
        pick_o[i] = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

  always_comb begin
    if (any_o) p_pick_onehot_r2: assert ($onehot(pick_o));
  end
endmodule

// File: rtl/dca_phase_fsm.sv
module dca_phase_fsm
  import dca_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int TURN_GAP  = 3,
  parameter int MAX_BEATS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any_req_i,
  input  logic [NUM_CH-1:0] pick_i,
  input  logic              beat_i,
  input  logic              last_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              phase_o,
  output logic              busy_o
);
  localparam int GAP_W  = (TURN_GAP < 1) ? 1 : $clog2(TURN_GAP + 1);
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);

  arb_state_e        state;
  logic [GAP_W-1:0]  gap_cnt;
  logic [BEAT_W-1:0] beat_cnt;
  logic              burst_end;

  assign burst_end = beat_i && (last_i || (beat_cnt == BEAT_W'(MAX_BEATS - 1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      gnt_o    <= '0;
      phase_o  <= 1'b0;
      busy_o   <= 1'b0;
      gap_cnt  <= '0;
      beat_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          beat_cnt <= '0;
          if (any_req_i) begin
            gnt_o   <= pick_i;
            state   <= ST_RD;
            busy_o  <= 1'b1;
            phase_o <= 1'b0;
          end
        end
        ST_RD: begin
          if (burst_end) begin
            beat_cnt <= '0;
            phase_o  <= 1'b1;
            if (TURN_GAP == 0) begin
              state  <= ST_WR;
              busy_o <= 1'b1;
            end else begin
              state   <= ST_GAP;
              busy_o  <= 1'b0;
              gap_cnt <= GAP_W'(TURN_GAP);
            end
          end else if (beat_i) begin
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gap_cnt <= GAP_W'(1)) begin
            state  <= ST_WR;
            busy_o <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        ST_WR: begin
          if (burst_end) begin
            beat_cnt <= '0;
            state    <= ST_IDLE;
            gnt_o    <= '0;
            busy_o   <= 1'b0;
            phase_o  <= 1'b0;
          end else if (beat_i) begin
            beat_cnt <= beat_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_gnt_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o));

  p_busy_has_gnt_r4: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (gnt_o != '0));

  p_hold_grant_r4: assert property (@(posedge clk) disable iff (rst)
    ((gnt_o != '0) && !((state == ST_WR) && burst_end)) |=> $stable(gnt_o));

  p_gap_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (!busy_o && phase_o && (gnt_o != '0)));

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_WR) && burst_end) |=> ((gnt_o == '0) && !busy_o));

  p_beat_cap_r9: assert property (@(posedge clk) disable iff (rst)
    (beat_cnt < BEAT_W'(MAX_BEATS)));
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int          NUM_CH      = 4,
  parameter int          TURN_GAP    = 3,
  parameter int          MAX_BEATS   = 16,
  parameter logic [31:0] BYPASS_MASK = 32'h0000_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              beat_i,
  input  logic              last_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              phase_o,
  output logic              busy_o
);
  logic [NUM_CH-1:0] req_s;
  logic [NUM_CH-1:0] pick;
  logic              any_req;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dca_req_sync #(.BYPASS(BYPASS_MASK[i])) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (req_i[i]),
        .q_o (req_s[i])
      );
    end
  endgenerate

  dca_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req_i  (req_s),
    .pick_o (pick),
    .any_o  (any_req)
  );

  dca_phase_fsm #(
    .NUM_CH    (NUM_CH),
    .TURN_GAP  (TURN_GAP),
    .MAX_BEATS (MAX_BEATS)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .any_req_i (any_req),
    .pick_i    (pick),
    .beat_i    (beat_i),
    .last_i    (last_i),
    .gnt_o     (gnt_o),
    .phase_o   (phase_o),
    .busy_o    (busy_o)
  );
endmodule

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int GAP  = 3;
  localparam int MAXB = 16;
  localparam int NVEC = 8;

  localparam logic [N-1:0] VEC_REQ [NVEC] = '{4'b0001, 4'b0110, 4'b1100, 4'b1000,
                                              4'b1111, 4'b1010, 4'b0100, 4'b1110};
  localparam logic [N-1:0] VEC_GNT [NVEC] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                              4'b0001, 4'b0010, 4'b0100, 4'b0010};

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] req;
  logic beat, last;
  logic [N-1:0] gnt;
  logic phase, busy;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_arbiter #(.NUM_CH(N), .TURN_GAP(GAP), .MAX_BEATS(MAXB),
                     .BYPASS_MASK(32'h3)) u_dma_chan_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .beat_i(beat), .last_i(last),
    .gnt_o(gnt), .phase_o(phase), .busy_o(busy));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_gnt(output int lat);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (gnt == '0 && lat < 8);
  endtask

  // Drive n beats; use_last marks the final beat.
  task automatic drive_burst(input int n, input bit use_last, input bit wr, input logic [N-1:0] g);
    for (int i = 0; i < n; i++) begin
      if (!(busy && phase == wr && gnt == g)) begin
        chk(1'b0, wr ? "R5 write-burst state" : "R4 read-burst state",
            {busy, phase, 28'(gnt)}, {1'b1, wr, 28'(g)});
      end
      beat = 1'b1;
      last = use_last && (i == n - 1);
      @(negedge clk);
    end
    beat = 1'b0;
    last = 1'b0;
  endtask

  task automatic count_gap(input logic [N-1:0] g);
    int n = 0;
    while (!busy && n < 20) begin
      if (!(phase && gnt == g)) chk(1'b0, "R5 gap holds grant", 32'(gnt), 32'(g));
      beat = (n == 0);   // R8: stray strobe in the gap
      last = (n == 0);
      @(negedge clk);
      beat = 1'b0;
      last = 1'b0;
      n++;
    end
    chk(n == GAP, "R5 gap length", n, GAP);
    chk(busy && phase && gnt == g, "R8 gap strobe ignored", 32'(gnt), 32'(g));
  endtask

  task automatic full_txn(input logic [N-1:0] g, input int rd, input int wr);
    drive_burst(rd, 1'b1, 1'b0, g);
    count_gap(g);
    drive_burst(wr, 1'b1, 1'b1, g);
    chk(gnt == '0 && !busy && !phase, "R6 release after write", {busy, 28'(gnt)}, 32'h0);
  endtask

  initial begin
    int lat;
    rst = 1'b1; req = '0; beat = 1'b0; last = 1'b0;
    repeat (3) @(negedge clk);
    chk(gnt == '0 && !busy && !phase, "R1 in reset", {busy, phase, 28'(gnt)}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(gnt == '0 && !busy && !phase, "R1 after reset", {busy, phase, 28'(gnt)}, 0);

    // R8: strobes while idle do nothing
    beat = 1'b1; last = 1'b1;
    @(negedge clk);
    beat = 1'b0; last = 1'b0;
    chk(gnt == '0 && !busy, "R8 idle strobe ignored", 32'(gnt), 0);

    // Table walk: R2 priority, R3 one-hot
    for (int v = 0; v < NVEC; v++) begin
      req = VEC_REQ[v];
      wait_gnt(lat);
      chk(gnt == VEC_GNT[v], "R2 priority pick", 32'(gnt), 32'(VEC_GNT[v]));
      chk($countones(gnt) == 1, "R3 one-hot grant", 32'(gnt), 32'(VEC_GNT[v]));
      req = '0;
      full_txn(VEC_GNT[v], 2, 3);
      repeat (3) @(negedge clk);
    end

    // R7 latency: bypassed channel 1 vs synchronized channel 3
    req = 4'b0010;
    wait_gnt(lat);
    chk(lat == 1, "R7 bypass latency", lat, 1);
    req = '0;
    full_txn(4'b0010, 1, 1);
    repeat (3) @(negedge clk);
    req = 4'b1000;
    wait_gnt(lat);
    chk(lat == 3, "R7 synced latency", lat, 3);

    // R4: channel 0 arrives mid-transaction and must wait
    req = 4'b0001;
    drive_burst(4, 1'b1, 1'b0, 4'b1000);
    count_gap(4'b1000);
    drive_burst(2, 1'b1, 1'b1, 4'b1000);
    chk(gnt == '0, "R6 one idle cycle", 32'(gnt), 0);
    @(negedge clk);
    chk(gnt == 4'b0001, "R4 waiting channel granted", 32'(gnt), 1);
    req = '0;

    // R10: short pulse during the transaction is lost
    drive_burst(1, 1'b0, 1'b0, 4'b0001);
    req = 4'b0010;
    @(negedge clk);
    req = '0;
    drive_burst(1, 1'b1, 1'b0, 4'b0001);
    count_gap(4'b0001);
    drive_burst(1, 1'b1, 1'b1, 4'b0001);
    repeat (4) @(negedge clk);
    chk(gnt == '0 && !busy, "R10 short pulse not granted", 32'(gnt), 0);

    // R9: read burst with no last strobe ends at MAX_BEATS
    req = 4'b0001;
    wait_gnt(lat);
    req = '0;
    drive_burst(MAXB - 1, 1'b0, 1'b0, 4'b0001);
    chk(busy && !phase, "R9 still reading before cap", {busy, phase}, 2);
    drive_burst(1, 1'b0, 1'b0, 4'b0001);
    chk(!busy && phase, "R9 burst capped", {busy, phase}, 1);
    count_gap(4'b0001);
    drive_burst(MAXB, 1'b0, 1'b1, 4'b0001);
    chk(gnt == '0 && !busy, "R9 write capped", 32'(gnt), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule